// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DDR SDRAM channel. It takes the memory from power-on to normal operation. After reset it holds the clock enable low through a stable-clock interval, then raises it with a no-operation cycle. It then issues a fixed series of commands on the memory command bus: a precharge of all banks, an extended mode write that enables the DLL, a mode write that resets the DLL, a second precharge of all banks, a programmable number of auto-refresh commands and a final mode write. The final mode write programs the operating settings with the DLL-reset bit clear.

Every gap between two commands is a parameter in clock cycles, and the block drives a no-operation command throughout each gap. When the wait after the final mode write has run out, a done flag rises and stays high. The two mode register values come in as ports. A one-cycle restart pulse sends the machine back to the DLL-reset write, so the DLL can relock after a change of clock frequency. Every wait parameter must be at least 2.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, cke stays low for exactly STABLE_CYC cycles. The next cycle drives cke high with a no-operation command, and cke never falls again.
- R2: One cycle after cke rises, the block issues a precharge-all: {ras_n,cas_n,we_n}=010, addr bit 10 high and every other address bit low, ba=00.
- R3: RP_CYC cycles after that precharge, the block issues an extended mode write: {ras_n,cas_n,we_n}=000, ba=01, addr equal to emr_value with bit 0 forced low (DLL enabled).
- R4: EXT_CYC cycles after the extended write, the block issues a mode write with ba=00 and addr equal to mr_value with bit 8 forced high (DLL reset).
- R5: LOCK_CYC cycles after the DLL-reset write, the block issues a second precharge-all encoded as in R2.
- R6: The block issues REF_NUM auto-refresh commands ({ras_n,cas_n,we_n}=001, ba=00, addr=0). The first comes RP_CYC cycles after the second precharge, and consecutive refreshes are RFC_CYC cycles apart.
- R7: RFC_CYC cycles after the last refresh, the block issues a mode write with ba=00 and addr equal to mr_value with bit 8 forced low.
- R8: init_done rises exactly MRD_CYC cycles after the final mode write. It then stays high with no-operation commands on the bus until a restart.
- R9: cs_n is always low. Every cycle that carries none of the commands above drives {ras_n,cas_n,we_n}=111 (no-operation).
- R10: A restart pulse sampled at a clock edge drops init_done at that edge. The DLL-reset write of R4 appears in the cycle after that edge, and the sequence resumes from R4 onward using the current port values. This applies at any time, including during a wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Restart from the DLL-reset write |
| emr_value | input | 12 | Extended mode register address value |
| mr_value | input | 12 | Mode register address value |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
The bench predicts the exact cycle, encoding, bank and address of every command and compares each one as it appears. A wait that is off by one cycle therefore shows up as a timing mismatch, and a dropped or extra refresh shows up as an out-of-order command. The DLL bits are exercised with mode values whose bit 8 and bit 0 hold the opposite of what the block must force. A design that passed these inputs through unchanged would leave the DLL disabled or leave it in reset after the final write. Two restarts are applied: one after completion with a new mode value, and one during the lock wait. A design that ignored the restart, resumed at the wrong step or kept its old countdown would show a missing or mistimed DLL-reset write, or init_done staying high.

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int STABLE_CYC = 50000,
  parameter int RP_CYC     = 6,
  parameter int EXT_CYC    = 20,
  parameter int LOCK_CYC   = 200,
  parameter int RFC_CYC    = 20,
  parameter int MRD_CYC    = 4,
  parameter int REF_NUM    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic [11:0] emr_value,
  input  logic [11:0] mr_value,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [11:0] addr,
  output logic        init_done
);
  localparam int M1   = (RP_CYC > EXT_CYC) ? RP_CYC : EXT_CYC;
  localparam int M2   = (LOCK_CYC > RFC_CYC) ? LOCK_CYC : RFC_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int M4   = (M3 > MRD_CYC) ? M3 : MRD_CYC;
  localparam int MAXW = (M4 > STABLE_CYC) ? M4 : STABLE_CYC;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int RW   = (REF_NUM > 1) ? $clog2(REF_NUM) : 1;

  typedef enum logic [3:0] {
    S_STABLE, S_CKEUP, S_PRE1, S_EMRS, S_MRS_DLL,
    S_PRE2, S_REF, S_MRS_FIN, S_DONE
  } step_t;

  step_t          step, step_nx;
  logic           waiting;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  ref_idx;
  logic           last_ref;
  int             gap;
  logic [2:0]     cmd;

  assign last_ref = (ref_idx == RW'(REF_NUM - 1));

  always_comb begin
    gap     = 2;
    step_nx = step;
    case (step)
      S_STABLE:  step_nx = S_CKEUP;
      S_CKEUP:   step_nx = S_PRE1;
      S_PRE1:    begin gap = RP_CYC;   step_nx = S_EMRS;    end
      S_EMRS:    begin gap = EXT_CYC;  step_nx = S_MRS_DLL; end
      S_MRS_DLL: begin gap = LOCK_CYC; step_nx = S_PRE2;    end
      S_PRE2:    begin gap = RP_CYC;   step_nx = S_REF;     end
      S_REF:     begin gap = RFC_CYC;  step_nx = last_ref ? S_MRS_FIN : S_REF; end
      S_MRS_FIN: begin gap = MRD_CYC;  step_nx = S_DONE;    end
      default:   step_nx = S_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= S_STABLE;
      waiting <= 1'b1;
      cnt     <= CW'(STABLE_CYC);
      ref_idx <= '0;
    end else if (restart) begin
      step    <= S_MRS_DLL;
      waiting <= 1'b0;
      ref_idx <= '0;
    end else if (step == S_CKEUP) begin
      step <= S_PRE1;
    end else if (step != S_DONE) begin
      if (!waiting) begin
        waiting <= 1'b1;
        cnt     <= CW'(gap - 1);
      end else if (cnt == CW'(1)) begin
        waiting <= 1'b0;
        step    <= step_nx;
        if (step == S_REF && !last_ref) ref_idx <= ref_idx + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    cmd  = 3'b111;
    ba   = 2'b00;
    addr = '0;
    if (!waiting) begin
      case (step)
        S_PRE1, S_PRE2: begin cmd = 3'b010; addr = 12'h400; end
        S_EMRS:    begin cmd = 3'b000; ba = 2'b01; addr = {emr_value[11:1], 1'b0}; end
        S_MRS_DLL: begin cmd = 3'b000; addr = {mr_value[11:9], 1'b1, mr_value[7:0]}; end
        S_REF:     cmd = 3'b001;
        S_MRS_FIN: begin cmd = 3'b000; addr = {mr_value[11:9], 1'b0, mr_value[7:0]}; end
        default:   ;
      endcase
    end
  end

  assign {ras_n, cas_n, we_n} = cmd;
  assign cs_n      = 1'b0;
  assign cke       = (step != S_STABLE);
  assign init_done = (step == S_DONE);
endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [11:0] addr,
  input logic        init_done
);
  logic is_nop, is_pre, is_mrs;
  assign is_nop = ({ras_n, cas_n, we_n} == 3'b111);
  assign is_pre = ({ras_n, cas_n, we_n} == 3'b010);
  assign is_mrs = ({ras_n, cas_n, we_n} == 3'b000);

  AST_CKE_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke); // R1
  AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> is_nop); // R1
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> addr[10]); // R2
  AST_EXT_DLL_ON: assert property (@(posedge clk) disable iff (!rst_n) (is_mrs && ba == 2'b01) |-> !addr[0]); // R3
  AST_MODE_BANK: assert property (@(posedge clk) disable iff (!rst_n) is_mrs |-> !ba[1]); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (init_done && !restart) |=> init_done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> is_nop); // R8
  AST_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cs_n); // R9
  AST_RESTART_DLL: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (is_mrs && ba == 2'b00 && addr[8] && !init_done)); // R10
endmodule

bind dram_init_seq dram_init_seq_chk chk (.*);

// File: tb/dram_init_seq_test.sv
module dram_init_seq_test;
  localparam int TS = 10, TRP = 3, TEXT = 5, TLOCK = 8, TRFC = 6, TMRD = 4, NREF = 2;
  localparam logic [2:0] K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000;

  logic clk = 0, rst_n = 0, restart = 0;
  logic [11:0] emr_value = 12'h043, mr_value = 12'h1F3;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [11:0] addr;

  dram_init_seq #(.STABLE_CYC(TS), .RP_CYC(TRP), .EXT_CYC(TEXT), .LOCK_CYC(TLOCK),
                  .RFC_CYC(TRFC), .MRD_CYC(TMRD), .REF_NUM(NREF)) uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .emr_value(emr_value),
    .mr_value(mr_value), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

  always #2 clk = ~clk;

  int n = 0, checks = 0, errors = 0, done_at = 1 << 30;
  bit finished = 0;
  int q_n[$];
  logic [2:0] q_k[$];
  logic [1:0] q_b[$];
  logic [11:0] q_a[$];
  string q_t[$];

  always @(posedge clk) if (rst_n) n <= n + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, n, act, exp);
    end
  endtask

  task automatic push(input int at, input logic [2:0] k, input logic [1:0] b, input logic [11:0] a, input string t);
    q_n.push_back(at); q_k.push_back(k); q_b.push_back(b); q_a.push_back(a); q_t.push_back(t);
  endtask

  task automatic push_from_dll(input int m, input logic [11:0] mr, output int dn);
    int t;
    t = m;
    push(t, K_MRS, 2'b00, mr | 12'h100, "R4");
    t += TLOCK; push(t, K_PRE, 2'b00, 12'h400, "R5");
    t += TRP;
    for (int i = 0; i < NREF; i++) begin
      push(t, K_REF, 2'b00, 12'h000, "R6");
      t += TRFC;
    end
    push(t, K_MRS, 2'b00, mr & ~12'h100, "R7");
    dn = t + TMRD;
  endtask

  task automatic pulse_restart(input int m);
    while (n != m - 1) @(negedge clk);
    restart = 1;
    @(posedge clk);
    #1 restart = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(cke == 0, "R1", "cke in reset", cke, 0);
      check(init_done == 0, "R8", "done in reset", init_done, 0);
    end else if (!finished) begin
      check(cke == (n >= TS), "R1", "cke", cke, n >= TS);
      check(init_done == (n >= done_at), "R8", "init_done", init_done, n >= done_at);
      check(cs_n == 0, "R9", "cs_n", cs_n, 0);
      if ({ras_n, cas_n, we_n} != 3'b111) begin
        if (q_n.size() == 0) check(0, "R9", "unexpected command", {ras_n, cas_n, we_n}, 7);
        else begin
          int en; logic [2:0] ek; logic [1:0] eb; logic [11:0] ea; string et;
          en = q_n.pop_front(); ek = q_k.pop_front(); eb = q_b.pop_front();
          ea = q_a.pop_front(); et = q_t.pop_front();
          check(n == en, et, "command cycle", n, en);
          check({ras_n, cas_n, we_n} == ek, et, "command code", {ras_n, cas_n, we_n}, ek);
          check(ba == eb, et, "bank", ba, eb);
          check(addr == ea, et, "address", addr, ea);
        end
      end else if (q_n.size() != 0 && n > q_n[0]) begin
        check(0, q_t[0], "missing command", n, q_n[0]);
        void'(q_n.pop_front()); void'(q_k.pop_front()); void'(q_b.pop_front());
        void'(q_a.pop_front()); void'(q_t.pop_front());
      end
    end
  end

  initial begin
    int dn, m;
    push(TS + 1, K_PRE, 2'b00, 12'h400, "R2");
    push(TS + 1 + TRP, K_MRS, 2'b01, 12'h042, "R3");
    push_from_dll(TS + 1 + TRP + TEXT, mr_value, dn);
    done_at = dn;
    repeat (3) @(negedge clk);
    rst_n = 1;
    while (n < done_at + 5) @(negedge clk);
    m = n + 3;
    pulse_restart(m);
    #1 done_at = 1 << 30;
    mr_value = 12'h031;
    void'(q_n.size());
    push(m, K_MRS, 2'b00, 12'h131, "R10");
    m = m + 3;
    pulse_restart(m);
    push_from_dll(m, 12'h031, dn);
    done_at = dn;
    while (n < done_at + 6) @(negedge clk);
    check(q_n.size() == 0, "R8", "pending commands", q_n.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule